// File: doc/BRIEF.md
# Pipelined No-Wait-State Burst SRAM

A synchronous static RAM with a 48-bit word split into six 8-bit byte lanes. Addresses and controls are registered on the rising clock edge, and read data leaves through a registered output stage. Reads and writes can be mixed in any order on consecutive cycles with no idle cycle between them. Write data follows its address by two enabled clocks, so it shares the bus slot that a read issued in the same cycle would use. An active-low clock enable freezes every stage of the block. The depth is a parameter, with a small default so that simulation stays light.

Each cycle either loads a fresh address and operation, or advances the current four-word burst from the last loaded one. A static mode pin chooses between a linear and an interleaved burst order. Three chip selects of mixed polarity must all be active for a load to start an access. The bus driver is modelled as a data output plus a drive-enable output. The enable drops during write data slots, during deselected slots and whenever the asynchronous output enable is inactive.

Top module: `nowait_sram`

## Requirements
- R1: With `cen_n` low at edge k, a selected read load (`adv_step`=0, `we_n`=1) places the word at `addr` on `dq_out` at enabled edge k+1, with `dq_drv` high (while `oe_n` is low) until the next enabled edge.
- R2: A selected write load (`we_n`=0) captured at enabled edge k takes its data from `dq_in` at the second following enabled edge, k+2.
- R3: `bwe_n[i]` low (captured with the address) writes bits 8i+7..8i. A lane whose bit is high keeps its stored byte.
- R4: Reads and writes may be issued on every enabled cycle in any mix. A read issued in the cycle right after a write to the same address returns the merged new word.
- R5: With `burst_ilv`=0, each cycle with `adv_step`=1 moves to the next burst word: the low two address bits are base+1, +2, +3, then base again (mod 4), with the upper bits taken from the loaded address. During advance cycles the operation type comes from the load, and `we_n`, `addr` and the chip selects are ignored.
- R6: With `burst_ilv`=1, the low two address bits of the n-th advance are base XOR (n mod 4).
- R7: While `cen_n` is high, an edge captures nothing: the stages, the burst state, `dq_out` and `dq_drv` hold, and `dq_in` is not sampled.
- R8: A load starts an access only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other load is a no-op whose data slot has `dq_drv` low and which leaves memory unchanged. Advances that follow such a load are also no-ops.
- R9: `dq_drv` is low during the data slot of every write.
- R10: `oe_n` high forces `dq_drv` low at once, without clocking, and has no effect on the pipeline.
- R11: Reset (`rst_n` low) empties the pipeline and the burst state, so `dq_drv` is low. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| cen_n | input | 1 | Active-low clock enable |
| adv_step | input | 1 | 1 = advance burst, 0 = load new address and operation |
| we_n | input | 1 | Active-low write on a load cycle |
| bwe_n | input | 6 | Active-low byte-lane write enables |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | $clog2(DEPTH) | Word address |
| dq_in | input | 48 | Write data from the bus |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | 48 | Registered read data |
| dq_drv | output | 1 | Bus driver enable (low = high impedance) |

## Verification
The two functions that can meet in one cycle are the commit of a write's data and the read of that same word by the operation issued one cycle after it. At that edge the word is not yet in storage, so the read must be served from the bus data. The bench provokes this with write/read pairs to one address, using full and partial lane masks, inside bursts, and with clock-enable freezes placed between the two operations. Each read result is judged against a scoreboard memory that is updated at the moment the bench drives the write data.

// File: rtl/nws_pkg.sv
package nws_pkg;

   localparam int unsigned LANE_W = 8;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // low two word-address bits of a burst beat
   function automatic logic [1:0] beat_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
      return ilv ? (base ^ cnt) : (base + cnt);
   endfunction

endpackage

// File: rtl/nws_burst_seq.sv
module nws_burst_seq
   import nws_pkg::*;
#(
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          adv_step,
   input  logic          sel_ok,
   input  logic          we_n,
   input  logic          burst_ilv,
   input  logic [AW-1:0] addr,
   output op_e           nxt_op,
   output logic [AW-1:0] nxt_addr
);

   logic [AW-1:0] bst_base;
   logic [1:0]    bst_cnt;
   op_e           bst_op;
   logic [1:0]    step_cnt;
   logic [1:0]    step_lo;
   logic [AW-1:0] step_addr;
   op_e           load_op;

   assign step_cnt = bst_cnt + 2'd1;
   assign step_lo  = beat_low(bst_base[1:0], step_cnt, burst_ilv);

   generate
      if (AW > 2) begin : g_hi
         assign step_addr = {bst_base[AW-1:2], step_lo};
      end else begin : g_lo
         assign step_addr = step_lo;
      end
   endgenerate

   always_comb begin
      if (!sel_ok)    load_op = OP_IDLE;
      else if (we_n)  load_op = OP_READ;
      else            load_op = OP_WRITE;
   end

   always_comb begin
      if (adv_step) begin
         nxt_op   = bst_op;
         nxt_addr = step_addr;
      end else begin
         nxt_op   = load_op;
         nxt_addr = addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bst_base <= '0;
         bst_cnt  <= '0;
         bst_op   <= OP_IDLE;
      end else if (en) begin
         if (adv_step) begin
            bst_cnt <= step_cnt;
         end else begin
            bst_base <= addr;
            bst_cnt  <= '0;
            bst_op   <= load_op;
         end
      end
   end

endmodule

// File: rtl/nws_lane_store.sv
module nws_lane_store
   import nws_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned LANES = 6,
   parameter int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned WW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [LANES-1:0] wr_lane_n,
   input  logic [WW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WW-1:0]    rd_word
);

   logic [WW-1:0] mem [DEPTH];
   logic [WW-1:0] stored;
   logic          hit;

   assign stored = mem[rd_addr];
   assign hit    = wr_en && (wr_addr == rd_addr);

   // per-lane bypass of the write committing at this same edge
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign rd_word[g*LANE_W +: LANE_W] =
            (hit && !wr_lane_n[g]) ? wr_data[g*LANE_W +: LANE_W]
                                   : stored[g*LANE_W +: LANE_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int i = 0; i < LANES; i++) begin
            if (!wr_lane_n[i])
               mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
         end
      end
   end

endmodule

// File: rtl/nws_out_stage.sv
module nws_out_stage #(
   parameter int unsigned WW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          slot_read,
   input  logic [WW-1:0] rd_word,
   input  logic          oe_n,
   output logic [WW-1:0] dq_out,
   output logic          dq_drv
);

   logic          drv_q;
   logic [WW-1:0] dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= 1'b0;
         dat_q <= '0;
      end else if (en) begin
         drv_q <= slot_read;
         if (slot_read) dat_q <= rd_word;
      end
   end

   assign dq_out = dat_q;
   assign dq_drv = drv_q & ~oe_n;

endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
   import nws_pkg::*;
#(
   parameter  int unsigned DEPTH  = 64,
   parameter  int unsigned LANES  = 6,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cen_n,
   input  logic              adv_step,
   input  logic              we_n,
   input  logic [LANES-1:0]  bwe_n,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              burst_ilv,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] dq_in,
   input  logic              oe_n,
   output logic [WORD_W-1:0] dq_out,
   output logic              dq_drv
);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("nowait_sram: DEPTH must be a power of two of at least 4");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("nowait_sram: LANES must be at least 1");
      end
   endgenerate

   logic          en;
   logic          sel_ok;
   op_e           nxt_op;
   logic [AW-1:0] nxt_addr;

   // address/control stage
   op_e              s1_op;
   logic [AW-1:0]    s1_addr;
   logic [LANES-1:0] s1_lane_n;
   // write-data stage
   logic             s2_wr;
   logic [AW-1:0]    s2_addr;
   logic [LANES-1:0] s2_lane_n;

   logic [WORD_W-1:0] rd_word;

   assign en     = ~cen_n;
   assign sel_ok = ~sel0_n & sel1 & ~sel2_n;

   nws_burst_seq #(.AW(AW)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .adv_step  (adv_step),
      .sel_ok    (sel_ok),
      .we_n      (we_n),
      .burst_ilv (burst_ilv),
      .addr      (addr),
      .nxt_op    (nxt_op),
      .nxt_addr  (nxt_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op     <= OP_IDLE;
         s1_addr   <= '0;
         s1_lane_n <= '1;
         s2_wr     <= 1'b0;
         s2_addr   <= '0;
         s2_lane_n <= '1;
      end else if (en) begin
         s1_op     <= nxt_op;
         s1_addr   <= nxt_addr;
         s1_lane_n <= bwe_n;
         s2_wr     <= (s1_op == OP_WRITE);
         s2_addr   <= s1_addr;
         s2_lane_n <= s1_lane_n;
      end
   end

   nws_lane_store #(.DEPTH(DEPTH), .LANES(LANES), .AW(AW)) u_store (
      .clk       (clk),
      .wr_en     (en & s2_wr),
      .wr_addr   (s2_addr),
      .wr_lane_n (s2_lane_n),
      .wr_data   (dq_in),
      .rd_addr   (s1_addr),
      .rd_word   (rd_word)
   );

   nws_out_stage #(.WW(WORD_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .slot_read (s1_op == OP_READ),
      .rd_word   (rd_word),
      .oe_n      (oe_n),
      .dq_out    (dq_out),
      .dq_drv    (dq_drv)
   );

endmodule

// File: rtl/nws_checker.sv
module nws_checker #(
   parameter int unsigned WW = 48
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cen_n,
   input logic          adv_step,
   input logic          we_n,
   input logic          sel0_n,
   input logic          sel1,
   input logic          sel2_n,
   input logic          oe_n,
   input logic [WW-1:0] dq_out,
   input logic          dq_drv
);

   logic load_sel;
   logic load_desel;

   assign load_sel   = !adv_step && !sel0_n && sel1 && !sel2_n;
   assign load_desel = !adv_step && !(!sel0_n && sel1 && !sel2_n);

   // R7: a frozen edge leaves the output register untouched
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cen_n |=> $stable(dq_out));

   // R8: a deselected load gives an undriven data slot
   assert_desel_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && $past(rst_n && !cen_n && load_desel)) |=> !dq_drv);

   // R9: bus released during a write data slot
   assert_write_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && $past(rst_n && !cen_n && load_sel && !we_n)) |=> !dq_drv);

   // R1: read data slot is driven unless the output enable is off
   assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && $past(rst_n && !cen_n && load_sel && we_n)) |=> (dq_drv || oe_n));

   // R11: leaving reset with the bus undriven
   assert_reset_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dq_drv);

endmodule

bind nowait_sram nws_checker #(.WW(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cen_n    (cen_n),
   .adv_step (adv_step),
   .we_n     (we_n),
   .sel0_n   (sel0_n),
   .sel1     (sel1),
   .sel2_n   (sel2_n),
   .oe_n     (oe_n),
   .dq_out   (dq_out),
   .dq_drv   (dq_drv)
);

// File: tb/tb_nowait_sram.sv
`timescale 1ns/1ps
module tb_nowait_sram;

   localparam int DEPTH = 64;
   localparam int LANES = 6;
   localparam int AW    = 6;
   localparam int W     = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cen_n = 1'b0;
   logic          adv_step = 1'b0;
   logic          we_n = 1'b1;
   logic [5:0]    bwe_n = '1;
   logic          sel0_n = 1'b1;
   logic          sel1 = 1'b1;
   logic          sel2_n = 1'b0;
   logic          burst_ilv = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  dq_in = '0;
   logic          oe_n = 1'b0;
   logic [W-1:0]  dq_out;
   logic          dq_drv;

   always #2 clk = ~clk;

   nowait_sram #(.DEPTH(DEPTH), .LANES(LANES)) dut (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_step(adv_step), .we_n(we_n),
      .bwe_n(bwe_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .burst_ilv(burst_ilv), .addr(addr), .dq_in(dq_in), .oe_n(oe_n),
      .dq_out(dq_out), .dq_drv(dq_drv)
   );

   typedef struct {
      int            kind;   // 0 none, 1 read, 2 write
      logic [AW-1:0] a;
      logic [5:0]    bw;
      logic [W-1:0]  d;
      string         tag;
   } slot_t;

   slot_t         q[$];
   slot_t         cur;
   bit            prev_en;
   logic [W-1:0]  refm [DEPTH];
   int            b_kind;
   logic [AW-1:0] b_base;
   logic [1:0]    b_cnt;
   int            errors = 0;
   int            checks = 0;
   bit            done = 0;

   task automatic chk(input bit ok, input string tag,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] rnd48();
      return {16'($urandom), 32'($urandom)};
   endfunction

   // one cycle: monitor the current data slot, then drive the next inputs
   task automatic tick(input bit c_n, input bit adv, input bit wen,
                       input bit s0n, input bit s1v, input bit s2n,
                       input logic [5:0] bw, input logic [AW-1:0] a,
                       input logic [W-1:0] wd, input string tag,
                       input bit oe_probe);
      string t;
      slot_t n;
      logic [1:0] lo;
      @(negedge clk);
      if (prev_en) begin
         cur = q.pop_front();
         if (cur.kind == 1) cur.d = refm[cur.a];
         t = cur.tag;
      end else begin
         t = {"R7 hold/", cur.tag};
      end
      if (cur.kind == 1) begin
         chk(dq_drv === 1'b1 && dq_out === cur.d, t, dq_out, cur.d);
         if (oe_probe) begin
            oe_n = 1'b1;
            #0.5;
            chk(dq_drv === 1'b0, "R10 oe_n high", W'(dq_drv), '0);
            oe_n = 1'b0;
            #0.5;
            chk(dq_drv === 1'b1 && dq_out === cur.d, "R10 oe_n restored", dq_out, cur.d);
         end
      end else begin
         chk(dq_drv === 1'b0, t, W'(dq_drv), '0);
      end
      // bus data: only a write slot at an enabled edge is meaningful
      if (cur.kind == 2 && !c_n) begin
         dq_in = cur.d;
         for (int i = 0; i < LANES; i++)
            if (!cur.bw[i]) refm[cur.a][i*8 +: 8] = cur.d[i*8 +: 8];
      end else begin
         dq_in = rnd48();
      end
      cen_n = c_n; adv_step = adv; we_n = wen;
      sel0_n = s0n; sel1 = s1v; sel2_n = s2n; bwe_n = bw; addr = a;
      if (!c_n) begin
         n.a = a; n.bw = bw; n.d = wd; n.tag = tag;
         if (!adv) begin
            if (!s0n && s1v && !s2n) begin
               b_kind = wen ? 1 : 2; b_base = a; b_cnt = 2'd0;
            end else begin
               b_kind = 0;
            end
         end else begin
            b_cnt = b_cnt + 2'd1;
            lo = burst_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
            n.a = {b_base[AW-1:2], lo};
         end
         n.kind = b_kind;
         q.push_back(n);
      end
      prev_en = !c_n;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag, input bit probe = 0);
      tick(0, 0, 1, 0, 1, 0, 6'($urandom), a, rnd48(), tag, probe);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d,
                     input logic [5:0] bw, input string tag);
      tick(0, 0, 0, 0, 1, 0, bw, a, d, tag, 0);
   endtask

   // advance with junk on the ignored inputs
   task automatic adv(input logic [5:0] bw, input logic [W-1:0] d, input string tag);
      tick(0, 1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           bw, 6'($urandom), d, tag, 0);
   endtask

   task automatic nop(input string tag);
      tick(0, 0, 1'($urandom), 1, 1, 0, 6'($urandom), 6'($urandom), rnd48(), tag, 0);
   endtask

   task automatic frz();
      tick(1, 1'($urandom), 1'($urandom), 0, 1, 0, 6'($urandom), 6'($urandom),
           rnd48(), "R7", 0);
   endtask

   initial begin
      slot_t idle;
      idle.kind = 0; idle.a = '0; idle.bw = '1; idle.d = '0; idle.tag = "R11 reset";
      q.push_back(idle); q.push_back(idle);
      cur = idle; prev_en = 1; b_kind = 0; b_base = '0; b_cnt = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dq_drv === 1'b0, "R11 drive off in reset", W'(dq_drv), '0);
      rst_n = 1'b1;

      // fill every word, back to back (R2)
      for (int i = 0; i < DEPTH; i++) wr(6'(i), rnd48(), 6'h00, "R2 fill");
      for (int i = 0; i < DEPTH; i++) rd(6'(i), "R1 readback");

      // zero-wait turnaround and bypass (R4, R3)
      wr(6'd8, 48'h1111_2222_3333, 6'h00, "R4 write");
      rd(6'd8, "R4 read right after write");
      rd(6'd3, "R4 read");
      wr(6'd3, 48'hAABB_CCDD_EEFF, 6'b101010, "R3 partial write");
      rd(6'd3, "R3 partial merge bypass");
      rd(6'd3, "R3 partial merge stored");
      wr(6'd9, 48'h0F0F_0F0F_0F0F, 6'b111110, "R3 lane0 only");
      wr(6'd10, 48'h1234_5678_9ABC, 6'b011111, "R3 lane5 only");
      rd(6'd9, "R3 lane0");
      rd(6'd10, "R3 lane5");
      wr(6'd11, 48'hFFFF_FFFF_FFFF, 6'h3F, "R3 no lanes");
      rd(6'd11, "R3 no lanes kept");

      // linear burst read from base with low bits 01, wrap (R5)
      burst_ilv = 1'b0;
      rd(6'd5, "R5 burst load");
      adv(6'h00, rnd48(), "R5 beat1");
      adv(6'h00, rnd48(), "R5 beat2");
      adv(6'h00, rnd48(), "R5 beat3");
      adv(6'h00, rnd48(), "R5 wrap");
      // linear burst write, then read back
      wr(6'd22, 48'hA000_0000_0001, 6'h00, "R5 burst write");
      adv(6'h00, 48'hA000_0000_0002, "R5 write beat1");
      adv(6'b110011, 48'hA000_0000_0003, "R5 write beat2 R3");
      adv(6'h00, 48'hA000_0000_0004, "R5 write beat3");
      for (int i = 20; i < 24; i++) rd(6'(i), "R5 burst write readback");

      // interleaved (R6)
      nop("R8 idle"); nop("R8 idle");
      burst_ilv = 1'b1;
      wr(6'd30, 48'hB000_0000_0000, 6'h00, "R6 ilv write");
      adv(6'h00, 48'hB000_0000_0001, "R6 beat1");
      adv(6'h00, 48'hB000_0000_0002, "R6 beat2");
      adv(6'h00, 48'hB000_0000_0003, "R6 beat3");
      for (int i = 28; i < 32; i++) rd(6'(i), "R6 readback");
      rd(6'd29, "R6 ilv read load");
      adv(6'h00, rnd48(), "R6 read beat1");
      adv(6'h00, rnd48(), "R6 read beat2");
      adv(6'h00, rnd48(), "R6 read beat3");

      // chip selects (R8)
      tick(0, 0, 0, 1, 1, 0, 6'h00, 6'd2, rnd48(), "R8 sel0 off write", 0);
      tick(0, 0, 0, 0, 0, 0, 6'h00, 6'd2, rnd48(), "R8 sel1 off write", 0);
      tick(0, 0, 0, 0, 1, 1, 6'h00, 6'd2, rnd48(), "R8 sel2 off write", 0);
      adv(6'h00, rnd48(), "R8 advance after deselect");
      rd(6'd2, "R8 memory unchanged");
      tick(0, 0, 1, 1, 0, 1, 6'h00, 6'd2, rnd48(), "R8 deselected read", 0);

      // freeze (R7) with a read and a write in flight
      burst_ilv = 1'b0;
      wr(6'd40, 48'hC0C0_C0C0_C0C0, 6'h00, "R7 write across freeze");
      rd(6'd41, "R7 read across freeze");
      frz(); frz();
      rd(6'd40, "R7 read after frozen write");
      frz();
      nop("R7 idle"); nop("R7 idle");
      rd(6'd12, "R10 read", 1);
      rd(6'd13, "R10 read", 1);

      // random mixed traffic
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (i % 60 == 0) begin
            nop("R8 idle"); nop("R8 idle");
            burst_ilv = 1'($urandom);
         end
         if (r < 10)      frz();
         else if (r < 35) adv(6'($urandom), rnd48(), "R4 random advance");
         else if (r < 40) nop("R8 random deselect");
         else if (r < 70) rd(6'($urandom), "R4 random read", (r % 7) == 0);
         else             wr(6'($urandom), rnd48(), 6'($urandom), "R4 random write");
      end
      nop("drain"); nop("drain"); nop("drain");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule